// File: doc/BRIEF.md
# Byte-Wide Stored-Program Processor

This block is a compact processor that fetches, decodes and executes two-byte instructions held in its own 256-byte memory. It has sixteen 8-bit working registers, an 8-bit program counter and a 16-bit instruction register. Each instruction carries a 4-bit opcode in its top nibble and three operand nibbles. The operand nibbles select registers, give a memory address or give an immediate byte. The opcodes cover loads, stores, register copies, addition, bitwise logic, right rotation, a compare-and-branch against register 0, and halt.

The memory is single-ported with a synchronous read. While reset is held high, a loader port owns that memory port, so the environment can write a program and read bytes back. Memory is not cleared by reset. A program therefore survives reset, and results that a program stored stay readable after the run. When reset is released, execution starts at address 0. A halt instruction stops all fetching and raises the halted output until the next reset. A second register read port lets the environment inspect any working register at any time.

Top module: `cpu8_top`

## Requirements
- R1: While reset is high and in the first cycle after it, the program counter is 0, halted is low and every working register reads 0.
- R2: Instruction bytes are taken from PC (high byte) and PC+1 (low byte). PC then advances by 2 modulo 256, so execution past address 0xFE continues at 0x00.
- R3: Opcode 0x2 (2rXY) writes the immediate byte XY into register r.
- R4: Opcode 0x1 (1rXY) loads register r from memory byte XY. Opcode 0x3 (3rXY) writes register r into memory byte XY.
- R5: Opcode 0x4 (40ab) copies register a into register b and leaves register a unchanged.
- R6: Opcode 0x5 (5rst) writes the sum of registers s and t, modulo 256, into register r.
- R7: Opcodes 0x7, 0x8 and 0x9 (rst form) write s OR t, s AND t and s XOR t, in that order, into register r.
- R8: Opcode 0xA (Ar_n) rotates register r right by n positions, where n is the lowest nibble. A count of 8 or more acts as n modulo 8, and a count of 0 leaves the value unchanged.
- R9: Opcode 0xB (BrXY) sets PC to XY when register r equals register 0, and otherwise execution falls through to the next instruction. With r=0 the jump is always taken.
- R10: Opcode 0xC stops execution. Halted then stays high, PC stays where the fetch left it (the halt address plus 2), and no memory write or fetch follows until reset.
- R11: Opcodes 0x0, 0x6, 0xD, 0xE and 0xF change no register and no memory byte. Only PC moves on.
- R12: While reset is high, a loader write stores a byte at the loader address, and the byte at the loader address appears on the loader read output one cycle later. Memory contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also hands the memory port to the loader |
| ld_we | input | 1 | Loader write enable (used only while rst is high) |
| ld_addr | input | ADDR_W | Loader byte address |
| ld_wdata | input | DATA_W | Loader write byte |
| ld_rdata | output | DATA_W | Byte read from memory, one cycle after its address |
| peek_sel | input | clog2(REG_CNT) | Register selected for inspection |
| peek_data | output | DATA_W | Contents of the inspected register |
| pc | output | ADDR_W | Program counter |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench uses the default parameters: 8-bit data and addresses and sixteen registers. These are the only values the nibble encoding fits. With them, each directed program reaches every opcode value. The immediate and address fields cover the whole memory, so the bench can reach the 0xFE-to-0x00 wrap and both outcomes of the branch. A rotate count of 11 checks the modulo behaviour. Register and memory contents are read back through the inspection and loader ports.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    localparam int unsigned NIB_W = 4;

    typedef enum logic [3:0] {
        OP_NOP0 = 4'h0,
        OP_LDM  = 4'h1,
        OP_LDI  = 4'h2,
        OP_STM  = 4'h3,
        OP_MOV  = 4'h4,
        OP_ADD  = 4'h5,
        OP_NOP6 = 4'h6,
        OP_OR   = 4'h7,
        OP_AND  = 4'h8,
        OP_XOR  = 4'h9,
        OP_ROR  = 4'hA,
        OP_JEQ  = 4'hB,
        OP_HLT  = 4'hC,
        OP_NOPD = 4'hD,
        OP_NOPE = 4'hE,
        OP_NOPF = 4'hF
    } opcode_e;

    typedef struct packed {
        opcode_e          op;
        logic [NIB_W-1:0] n1;
        logic [NIB_W-1:0] n2;
        logic [NIB_W-1:0] n3;
    } instr_t;

    typedef enum logic [2:0] {
        ST_FETCH_HI,
        ST_FETCH_LO,
        ST_DECODE,
        ST_EXEC,
        ST_LOAD_WB,
        ST_HALT
    } state_e;

    typedef enum logic [2:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_OR,
        ALU_AND,
        ALU_XOR,
        ALU_ROR
    } alu_op_e;

    // Operation the ALU performs for a given opcode.
    function automatic alu_op_e alu_sel(opcode_e op);
        case (op)
            OP_ADD:  return ALU_ADD;
            OP_OR:   return ALU_OR;
            OP_AND:  return ALU_AND;
            OP_XOR:  return ALU_XOR;
            OP_ROR:  return ALU_ROR;
            default: return ALU_PASS;
        endcase
    endfunction

    // Opcodes of the three-register form: destination n1, sources n2 and n3.
    function automatic logic is_rst_form(opcode_e op);
        return (op == OP_ADD) || (op == OP_OR) || (op == OP_AND) || (op == OP_XOR);
    endfunction

    // Opcodes that write an ALU result back into register n1.
    function automatic logic writes_alu(opcode_e op);
        return is_rst_form(op) || (op == OP_ROR);
    endfunction

endpackage

// File: rtl/cpu8_mem.sv
module cpu8_mem #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Contents are deliberately not reset so a loaded program persists.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        rdata <= cells[addr];
    end
endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned REG_CNT = 16,
    localparam int unsigned SEL_W  = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  a_sel,
    output logic [DATA_W-1:0] a_data,
    input  logic [SEL_W-1:0]  b_sel,
    output logic [DATA_W-1:0] b_data,
    input  logic [SEL_W-1:0]  v_sel,
    output logic [DATA_W-1:0] v_data,
    input  logic              we,
    input  logic [SEL_W-1:0]  w_sel,
    input  logic [DATA_W-1:0] w_data
);
    logic [DATA_W-1:0] regs [REG_CNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_CNT; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[w_sel] <= w_data;
        end
    end

    assign a_data = regs[a_sel];
    assign b_data = regs[b_sel];
    assign v_data = regs[v_sel];

    // R1: every register reads zero in the cycle after reset was high
    p_clear_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (v_data == '0 && a_data == '0 && b_data == '0));
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
    import cpu8_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [NIB_W-1:0]  cnt,
    output logic [DATA_W-1:0] y
);
    localparam int unsigned ROT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [ROT_W-1:0]    rot_k;
    logic [2*DATA_W-1:0] doubled;
    logic [2*DATA_W-1:0] shifted;

    always_comb begin
        rot_k   = ROT_W'(32'(cnt) % DATA_W);
        doubled = {a, a};
        shifted = doubled >> rot_k;
        case (op)
            ALU_ADD: y = a + b;
            ALU_OR:  y = a | b;
            ALU_AND: y = a & b;
            ALU_XOR: y = a ^ b;
            ALU_ROR: y = shifted[DATA_W-1:0];
            default: y = a;
        endcase
    end
endmodule

// File: rtl/cpu8_top.sv
module cpu8_top
    import cpu8_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned REG_CNT = 16,
    localparam int unsigned SEL_W  = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_wdata,
    output logic [DATA_W-1:0] ld_rdata,
    input  logic [SEL_W-1:0]  peek_sel,
    output logic [DATA_W-1:0] peek_data,
    output logic [ADDR_W-1:0] pc,
    output logic              halted
);
    localparam logic [ADDR_W-1:0] PC_ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(2);

    state_e            state;
    instr_t            ir;
    logic [ADDR_W-1:0] pc_q;

    // CPU side of the memory port
    logic              cpu_we;
    logic [ADDR_W-1:0] cpu_addr;
    logic [DATA_W-1:0] cpu_wdata;
    // Shared memory port after the loader mux
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    logic [SEL_W-1:0]  ra_sel, rb_sel, wr_sel;
    logic [DATA_W-1:0] ra_data, rb_data, wr_data, alu_y;
    logic              wr_en;
    logic              regs_equal;
    logic [2*NIB_W-1:0] xy;

    assign xy         = {ir.n2, ir.n3};
    assign regs_equal = (ra_data == rb_data);

    // ---------------- operand routing ----------------
    always_comb begin
        ra_sel = SEL_W'(ir.n1);
        if (is_rst_form(ir.op) || ir.op == OP_MOV) begin
            ra_sel = SEL_W'(ir.n2);
        end
        rb_sel = (ir.op == OP_JEQ) ? '0 : SEL_W'(ir.n3);
    end

    cpu8_alu #(.DATA_W(DATA_W)) alu_i (
        .op  (alu_sel(ir.op)),
        .a   (ra_data),
        .b   (rb_data),
        .cnt (ir.n3),
        .y   (alu_y)
    );

    // ---------------- register write-back ----------------
    always_comb begin
        wr_en   = 1'b0;
        wr_sel  = SEL_W'(ir.n1);
        wr_data = alu_y;
        if (state == ST_EXEC) begin
            if (ir.op == OP_LDI) begin
                wr_en   = 1'b1;
                wr_data = DATA_W'(xy);
            end else if (ir.op == OP_MOV) begin
                wr_en   = 1'b1;
                wr_sel  = SEL_W'(ir.n3);
                wr_data = ra_data;
            end else if (writes_alu(ir.op)) begin
                wr_en   = 1'b1;
            end
        end else if (state == ST_LOAD_WB) begin
            wr_en   = 1'b1;
            wr_data = mem_rdata;
        end
    end

    cpu8_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) rf_i (
        .clk    (clk),
        .rst    (rst),
        .a_sel  (ra_sel),
        .a_data (ra_data),
        .b_sel  (rb_sel),
        .b_data (rb_data),
        .v_sel  (peek_sel),
        .v_data (peek_data),
        .we     (wr_en),
        .w_sel  (wr_sel),
        .w_data (wr_data)
    );

    // ---------------- memory access ----------------
    always_comb begin
        cpu_we    = 1'b0;
        cpu_addr  = pc_q;
        cpu_wdata = ra_data;
        case (state)
            ST_FETCH_LO: cpu_addr = pc_q + PC_ONE;
            ST_EXEC: begin
                if (ir.op == OP_LDM || ir.op == OP_STM) begin
                    cpu_addr = ADDR_W'(xy);
                end
                cpu_we = (ir.op == OP_STM);
            end
            default: ;
        endcase
        if (rst) begin
            mem_we    = ld_we;
            mem_addr  = ld_addr;
            mem_wdata = ld_wdata;
        end else begin
            mem_we    = cpu_we;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
        end
    end

    cpu8_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    assign ld_rdata = mem_rdata;

    // ---------------- controller ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FETCH_HI;
            pc_q  <= '0;
            ir    <= '0;
        end else begin
            case (state)
                ST_FETCH_HI: state <= ST_FETCH_LO;
                ST_FETCH_LO: begin
                    ir.op <= opcode_e'(mem_rdata[7:4]);
                    ir.n1 <= mem_rdata[3:0];
                    state <= ST_DECODE;
                end
                ST_DECODE: begin
                    ir.n2 <= mem_rdata[7:4];
                    ir.n3 <= mem_rdata[3:0];
                    pc_q  <= pc_q + PC_STEP;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (ir.op == OP_JEQ && regs_equal) begin
                        pc_q <= ADDR_W'(xy);
                    end
                    if (ir.op == OP_HLT) begin
                        state <= ST_HALT;
                    end else if (ir.op == OP_LDM) begin
                        state <= ST_LOAD_WB;
                    end else begin
                        state <= ST_FETCH_HI;
                    end
                end
                ST_LOAD_WB: state <= ST_FETCH_HI;
                default:    state <= ST_HALT;
            endcase
        end
    end

    assign pc     = pc_q;
    assign halted = (state == ST_HALT);

    // R2: program counter advances by two (mod 256) once both bytes are in
    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DECODE) |=> (pc == $past(pc) + PC_STEP));

    // R9: equal compare loads PC with the operand byte
    p_jump_taken_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && ir.op == OP_JEQ && regs_equal) |=> (pc == ADDR_W'($past(xy))));

    // R9: unequal compare leaves PC on the next instruction
    p_jump_fall_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && ir.op == OP_JEQ && !regs_equal) |=> $stable(pc));

    // R10: halt is sticky and freezes the program counter
    p_halt_hold_r10: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc)));

    // R10: a halted machine issues no memory write
    p_halt_no_store_r10: assert property (@(posedge clk) disable iff (rst)
        halted |-> !cpu_we);
endmodule

// File: tb/cpu8_top_tb_top.sv
`timescale 1ns/1ps
module cpu8_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_we = 1'b0;
    logic [7:0] ld_addr = '0;
    logic [7:0] ld_wdata = '0;
    logic [7:0] ld_rdata;
    logic [3:0] peek_sel = '0;
    logic [7:0] peek_data;
    logic [7:0] pc;
    logic       halted;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cpu8_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .ld_we     (ld_we),
        .ld_addr   (ld_addr),
        .ld_wdata  (ld_wdata),
        .ld_rdata  (ld_rdata),
        .peek_sel  (peek_sel),
        .peek_data (peek_data),
        .pc        (pc),
        .halted    (halted)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic put_word(int addr, logic [15:0] word);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = 8'(addr); ld_wdata = word[15:8];
        @(negedge clk);
        ld_addr = 8'(addr + 1); ld_wdata = word[7:0];
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic put_byte(int addr, logic [7:0] b);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = 8'(addr); ld_wdata = b;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    function automatic int read_reg_now(int sel);
        return 0;
    endfunction

    task automatic peek(int sel, output int val);
        peek_sel = 4'(sel);
        #1;
        val = int'(peek_data);
    endtask

    task automatic get_byte(int addr, output int val);
        @(negedge clk);
        ld_addr = 8'(addr);
        @(negedge clk);
        val = int'(ld_rdata);
    endtask

    task automatic run_to_halt(string req);
        int cyc;
        cyc = 0;
        @(negedge clk);
        rst = 1'b0;
        while (!halted && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        check({req, " halted"}, int'(halted), 1);
    endtask

    task automatic t_reset();
        int v;
        hold_reset();
        check("R1 pc", int'(pc), 0);
        check("R1 halted", int'(halted), 0);
        for (int i = 0; i < 16; i++) begin
            peek(i, v);
            check("R1 reg", v, 0);
        end
    endtask

    task automatic t_fibonacci();
        int v, pc_at_halt;
        hold_reset();
        put_word(8'h00, 16'h2000);
        put_word(8'h02, 16'h2100);
        put_word(8'h04, 16'h2201);
        put_word(8'h06, 16'h2408);
        put_word(8'h08, 16'h25FF);
        put_word(8'h0A, 16'h5312);
        put_word(8'h0C, 16'h4021);
        put_word(8'h0E, 16'h4032);
        put_word(8'h10, 16'h5445);
        put_word(8'h12, 16'hB416);
        put_word(8'h14, 16'hB00A);
        put_word(8'h16, 16'hC000);
        run_to_halt("R10 fib");
        peek(2, v); check("R6 R9 fib result r2", v, 8'h22);
        peek(1, v); check("R5 fib r1", v, 8'h15);
        peek(4, v); check("R6 R9 counter wrapped to r0", v, 0);
        peek(5, v); check("R3 r5 immediate", v, 8'hFF);
        check("R10 pc after halt", int'(pc), 8'h18);
        pc_at_halt = int'(pc);
        repeat (12) @(negedge clk);
        check("R10 halted sticky", int'(halted), 1);
        check("R10 pc frozen", int'(pc), pc_at_halt);
    endtask

    task automatic t_memory();
        int v;
        hold_reset();
        put_byte(8'h80, 8'h5A);
        put_word(8'h00, 16'h1380);
        put_word(8'h02, 16'h2A3C);
        put_word(8'h04, 16'h3A81);
        put_word(8'h06, 16'h3382);
        put_word(8'h08, 16'hC000);
        run_to_halt("R4 mem");
        peek(3, v);  check("R4 load from memory", v, 8'h5A);
        peek(10, v); check("R3 immediate", v, 8'h3C);
        hold_reset();
        get_byte(8'h81, v); check("R4 store of immediate reg", v, 8'h3C);
        get_byte(8'h82, v); check("R4 store of loaded reg", v, 8'h5A);
        get_byte(8'h00, v); check("R12 program survives reset", v, 8'h13);
        get_byte(8'h80, v); check("R12 preload readback", v, 8'h5A);
    endtask

    task automatic t_alu();
        int v;
        hold_reset();
        put_word(8'h00, 16'h21C5);
        put_word(8'h02, 16'h226C);
        put_word(8'h04, 16'h7312);
        put_word(8'h06, 16'h8412);
        put_word(8'h08, 16'h9512);
        put_word(8'h0A, 16'h5612);
        put_word(8'h0C, 16'h2781);
        put_word(8'h0E, 16'h4078);
        put_word(8'h10, 16'h4079);
        put_word(8'h12, 16'hA703);
        put_word(8'h14, 16'hA80B);
        put_word(8'h16, 16'hA900);
        put_word(8'h18, 16'hC000);
        run_to_halt("R7 alu");
        peek(3, v); check("R7 or", v, 8'hED);
        peek(4, v); check("R7 and", v, 8'h44);
        peek(5, v); check("R7 xor", v, 8'hA9);
        peek(6, v); check("R6 add wraps", v, 8'h31);
        peek(7, v); check("R8 rotate by 3", v, 8'h30);
        peek(8, v); check("R8 rotate by 11", v, 8'h30);
        peek(9, v); check("R8 rotate by 0", v, 8'h81);
        peek(1, v); check("R5 source kept", v, 8'hC5);
    endtask

    task automatic t_branch_nops();
        int v;
        hold_reset();
        put_word(8'h00, 16'h2105);
        put_word(8'h02, 16'hB10A);
        put_word(8'h04, 16'h2277);
        put_word(8'h06, 16'h6123);
        put_word(8'h08, 16'hF456);
        put_word(8'h0A, 16'h0789);
        put_word(8'h0C, 16'hD000);
        put_word(8'h0E, 16'hE111);
        put_word(8'h10, 16'hB014);
        put_word(8'h12, 16'h2333);
        put_word(8'h14, 16'hC000);
        run_to_halt("R9 branch");
        peek(2, v); check("R9 fall-through executes next", v, 8'h77);
        peek(3, v); check("R9 taken jump skips", v, 0);
        peek(1, v); check("R11 nop keeps r1", v, 8'h05);
        peek(4, v); check("R11 nop keeps r4", v, 0);
        peek(7, v); check("R11 nop keeps r7", v, 0);
        check("R9 pc after halt", int'(pc), 8'h16);
    endtask

    task automatic t_pc_wrap();
        int v;
        hold_reset();
        put_word(8'h00, 16'hBA04);
        put_word(8'h02, 16'hC000);
        put_word(8'h04, 16'hB0FE);
        put_word(8'hFE, 16'h2A11);
        run_to_halt("R2 wrap");
        peek(10, v); check("R2 executed at FE", v, 8'h11);
        check("R2 wrapped to 00 then halted", int'(pc), 8'h04);
    endtask

    initial begin
        t_reset();
        t_fibonacci();
        t_memory();
        t_alu();
        t_branch_nops();
        t_pc_wrap();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule